// File: doc/BRIEF.md
# GPIO Bank Interrupt Controller

This block is a memory-mapped controller for several banks of general-purpose pins. Each pin has a direction, an output value, a synchronised input value, a switch that hands the pad to the GPIO function or to an alternate function, and a per-pin interrupt setup. Every pin runs in one of two detection modes, level or edge, and a polarity bit selects which level or which edge counts. Status bits latch detections until software clears them. Each bank drives one interrupt line.

Registers are reached over a small 32-bit bus. A four-bit group code in address bits 7:4 selects a register kind, and the bank is selected by address bits 3:2, so the banks of one group occupy consecutive words. A three-state handshake machine serves the bus. In `BUS_IDLE`, a request is accepted: a write is applied and read data is captured. The machine then moves to `BUS_RESP` and raises ready for exactly one cycle. It moves unconditionally to `BUS_HOLD` and waits there for the request to drop before returning to `BUS_IDLE`.

Pads come from the bench or chip level as flat vectors, with pin `p` of bank `b` at index `b*30+p`. Input pads pass through a two-flop synchroniser. Edge detection compares the synchronised value with its value one clock earlier.

Top module: `pin_irq_ctrl`

## Requirements
- R1: After reset, every direction word reads 0x3FFFFFFF (all pins inputs). Polarity, type, enable, status, function-enable and output words read 0, and every bank interrupt is low.
- R2: Bits 31:30 of every word read 0 and ignore writes. The following read 0 and ignore writes: group code 1, bank index 3, and any address with bits 1:0 non-zero.
- R3: The word for bank n of a group sits at group base + 4*n. Group codes in address bits 7:4 are: direction 0, polarity 2, type 3, enable 4, status 5, function enable 6, input 7 (read-only), output 8.
- R4: When a pin's function-enable bit is 1, pad_oe is the inverse of its direction bit (1 = input), and pad_out is its output-data bit.
- R5: When a pin's function-enable bit is 0, pad_out and pad_oe follow alt_out and alt_oe, and fn_gpio shows the function-enable bit.
- R6: The input group returns the pad values through a two-flop synchroniser.
- R7: A pin with type 1 and polarity 1 sets its status bit on a rising edge. The bit stays set after the pad returns low.
- R8: A pin with type 1 and polarity 0 sets its status bit on a falling edge and ignores rising edges.
- R9: A pin with type 0 sets its status bit every cycle while the pad is at the active level (polarity 1 = high, 0 = low). A clear does not stick while that level holds, and does stick once the level has gone.
- R10: Writing 0 to a status bit clears it, and writing 1 leaves it unchanged. Without a status write, no status bit falls.
- R11: A bank interrupt is high exactly when some pin of that bank has direction, status and enable all 1. Output pins and masked pins never raise it.
- R12: bus_ready rises in the cycle after a request is accepted, stays high for one cycle, and stays low until the request has been released and made again.
- R13: A pad change that meets the selected condition shows on the bank interrupt after the third rising clock edge that follows it, and not after the second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Bus request, held until ready is seen |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address: group in 7:4, bank in 3:2 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | One-cycle completion strobe |
| pad_in | input | 90 | Pad input values |
| pad_out | output | 90 | Pad output values |
| pad_oe | output | 90 | Pad output enables |
| alt_out | input | 90 | Alternate-function output values |
| alt_oe | input | 90 | Alternate-function output enables |
| fn_gpio | output | 90 | 1 where the GPIO function owns the pin |
| bank_irq | output | 3 | One interrupt line per bank |

## Verification
A bus transfer is accepted on the first rising edge with the request high. Ready and read data are due before the next edge. A written value therefore takes effect on pads and interrupt lines from that same accept edge. A pad change needs three rising edges to reach status and the interrupt line: two synchroniser stages and then the status flop. The bench changes pads and bus signals on falling edges and counts rising edges explicitly before sampling on a falling edge. The latency check samples both one edge too early and at the due edge.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
    localparam int BUS_DW = 32;
    localparam int BUS_AW = 8;

    // register group codes in address bits 7:4
    localparam logic [3:0] G_DIR  = 4'h0;
    localparam logic [3:0] G_POL  = 4'h2;
    localparam logic [3:0] G_TYP  = 4'h3;
    localparam logic [3:0] G_ENA  = 4'h4;
    localparam logic [3:0] G_STS  = 4'h5;
    localparam logic [3:0] G_FEN  = 4'h6;
    localparam logic [3:0] G_DIN  = 4'h7;
    localparam logic [3:0] G_DOUT = 4'h8;

    typedef enum logic [1:0] {
        BUS_IDLE = 2'd0,
        BUS_RESP = 2'd1,
        BUS_HOLD = 2'd2
    } bus_state_e;
endpackage

// File: rtl/in_sync.sv
module in_sync #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    // pads idle high: both stages reset to ones so no edge is seen at start
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '1;
            q      <= '1;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/bank_slice.sv
module bank_slice
    import pin_irq_pkg::*;
#(
    parameter int PINS = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [3:0]      grp,
    input  logic [PINS-1:0] wdata,
    input  logic [PINS-1:0] pin_sync,
    input  logic [PINS-1:0] alt_out,
    input  logic [PINS-1:0] alt_oe,
    output logic [PINS-1:0] dir_q,
    output logic [PINS-1:0] pol_q,
    output logic [PINS-1:0] typ_q,
    output logic [PINS-1:0] ena_q,
    output logic [PINS-1:0] sts_q,
    output logic [PINS-1:0] fen_q,
    output logic [PINS-1:0] dout_q,
    output logic            irq,
    output logic [PINS-1:0] pad_out,
    output logic [PINS-1:0] pad_oe
);
    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] rise, fall, edge_hit, lvl_hit, hit, sts_keep;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '1;
            pol_q  <= '0;
            typ_q  <= '0;
            ena_q  <= '0;
            fen_q  <= '0;
            dout_q <= '0;
        end else if (wr_en) begin
            unique case (grp)
                G_DIR:   dir_q  <= wdata;
                G_POL:   pol_q  <= wdata;
                G_TYP:   typ_q  <= wdata;
                G_ENA:   ena_q  <= wdata;
                G_FEN:   fen_q  <= wdata;
                G_DOUT:  dout_q <= wdata;
                default: ;
            endcase
        end
    end

    // detection against the value one clock earlier
    always_comb begin
        rise     = pin_sync & ~prev_q;
        fall     = ~pin_sync & prev_q;
        edge_hit = (pol_q & rise) | (~pol_q & fall);
        lvl_hit  = (pol_q & pin_sync) | (~pol_q & ~pin_sync);
        hit      = (typ_q & edge_hit) | (~typ_q & lvl_hit);
        sts_keep = (wr_en && grp == G_STS) ? wdata : '1;
    end

    // a new detection wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
            sts_q  <= '0;
        end else begin
            prev_q <= pin_sync;
            sts_q  <= (sts_q & sts_keep) | hit;
        end
    end

    always_comb begin
        irq     = |(dir_q & sts_q & ena_q);
        pad_oe  = (fen_q & ~dir_q) | (~fen_q & alt_oe);
        pad_out = (fen_q & dout_q) | (~fen_q & alt_out);
    end
endmodule

// File: rtl/reg_bus_fsm.sv
module reg_bus_fsm
    import pin_irq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          we,
    input  logic [DW-1:0] rd_word,
    output logic          accept_wr,
    output logic          ready,
    output logic [DW-1:0] rdata
);
    bus_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: if (req) state_d = BUS_RESP;
            BUS_RESP: state_d = BUS_HOLD;
            BUS_HOLD: if (!req) state_d = BUS_IDLE;
            default:  state_d = BUS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= BUS_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        accept_wr = (state_q == BUS_IDLE) && req && we;
        ready     = (state_q == BUS_RESP);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= '0;
        else if (state_q == BUS_IDLE && req)
            rdata <= we ? '0 : rd_word;
    end
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
    import pin_irq_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    parameter int PINS      = 30
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_req,
    input  logic                      bus_we,
    input  logic [BUS_AW-1:0]         bus_addr,
    input  logic [BUS_DW-1:0]         bus_wdata,
    output logic [BUS_DW-1:0]         bus_rdata,
    output logic                      bus_ready,
    input  logic [NUM_BANKS*PINS-1:0] pad_in,
    output logic [NUM_BANKS*PINS-1:0] pad_out,
    output logic [NUM_BANKS*PINS-1:0] pad_oe,
    input  logic [NUM_BANKS*PINS-1:0] alt_out,
    input  logic [NUM_BANKS*PINS-1:0] alt_oe,
    output logic [NUM_BANKS*PINS-1:0] fn_gpio,
    output logic [NUM_BANKS-1:0]      bank_irq
);
    localparam int TOT = NUM_BANKS * PINS;
    localparam int PAD = BUS_DW - PINS;

    logic [3:0]      grp;
    logic [1:0]      bank_idx;
    logic            aligned, bank_ok, accept_wr, wr_stb, sts_wr;
    logic [BUS_DW-1:0] rd_word;
    logic            unused_hi;

    logic [PINS-1:0] sync_a [NUM_BANKS];
    logic [PINS-1:0] dir_a  [NUM_BANKS];
    logic [PINS-1:0] pol_a  [NUM_BANKS];
    logic [PINS-1:0] typ_a  [NUM_BANKS];
    logic [PINS-1:0] ena_a  [NUM_BANKS];
    logic [PINS-1:0] sts_a  [NUM_BANKS];
    logic [PINS-1:0] fen_a  [NUM_BANKS];
    logic [PINS-1:0] dout_a [NUM_BANKS];

    logic [TOT-1:0] dir_flat, ena_flat, sts_flat, fen_flat;

    assign grp       = bus_addr[7:4];
    assign bank_idx  = bus_addr[3:2];
    assign aligned   = (bus_addr[1:0] == 2'b00);
    assign bank_ok   = aligned && (32'(bank_idx) < NUM_BANKS);
    assign wr_stb    = accept_wr && bank_ok;
    assign sts_wr    = wr_stb && (grp == G_STS);
    assign unused_hi = ^bus_wdata[BUS_DW-1:PINS];

    reg_bus_fsm #(.DW(BUS_DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (bus_req),
        .we        (bus_we),
        .rd_word   (rd_word),
        .accept_wr (accept_wr),
        .ready     (bus_ready),
        .rdata     (bus_rdata)
    );

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        in_sync #(.W(PINS)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (pad_in[b*PINS +: PINS]),
            .q     (sync_a[b])
        );

        bank_slice #(.PINS(PINS)) u_slice (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_stb && (32'(bank_idx) == b)),
            .grp      (grp),
            .wdata    (bus_wdata[PINS-1:0]),
            .pin_sync (sync_a[b]),
            .alt_out  (alt_out[b*PINS +: PINS]),
            .alt_oe   (alt_oe[b*PINS +: PINS]),
            .dir_q    (dir_a[b]),
            .pol_q    (pol_a[b]),
            .typ_q    (typ_a[b]),
            .ena_q    (ena_a[b]),
            .sts_q    (sts_a[b]),
            .fen_q    (fen_a[b]),
            .dout_q   (dout_a[b]),
            .irq      (bank_irq[b]),
            .pad_out  (pad_out[b*PINS +: PINS]),
            .pad_oe   (pad_oe[b*PINS +: PINS])
        );

        assign dir_flat[b*PINS +: PINS] = dir_a[b];
        assign ena_flat[b*PINS +: PINS] = ena_a[b];
        assign sts_flat[b*PINS +: PINS] = sts_a[b];
        assign fen_flat[b*PINS +: PINS] = fen_a[b];
    end

    assign fn_gpio = fen_flat;

    always_comb begin
        rd_word = '0;
        if (bank_ok) begin
            unique case (grp)
                G_DIR:   rd_word = {{PAD{1'b0}}, dir_a[bank_idx]};
                G_POL:   rd_word = {{PAD{1'b0}}, pol_a[bank_idx]};
                G_TYP:   rd_word = {{PAD{1'b0}}, typ_a[bank_idx]};
                G_ENA:   rd_word = {{PAD{1'b0}}, ena_a[bank_idx]};
                G_STS:   rd_word = {{PAD{1'b0}}, sts_a[bank_idx]};
                G_FEN:   rd_word = {{PAD{1'b0}}, fen_a[bank_idx]};
                G_DIN:   rd_word = {{PAD{1'b0}}, sync_a[bank_idx]};
                G_DOUT:  rd_word = {{PAD{1'b0}}, dout_a[bank_idx]};
                default: rd_word = '0;
            endcase
        end
    end
endmodule

// File: rtl/pin_irq_chk.sv
module pin_irq_chk #(
    parameter int NUM_BANKS = 3,
    parameter int PINS      = 30
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      bus_req,
    input logic                      bus_ready,
    input logic [NUM_BANKS-1:0]      bank_irq,
    input logic [NUM_BANKS*PINS-1:0] pad_oe,
    input logic [NUM_BANKS*PINS-1:0] dir_flat,
    input logic [NUM_BANKS*PINS-1:0] ena_flat,
    input logic [NUM_BANKS*PINS-1:0] sts_flat,
    input logic [NUM_BANKS*PINS-1:0] fen_flat,
    input logic                      sts_wr
);
    p_ready_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ready |=> !bus_ready);

    p_ready_needs_req_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_ready) |-> $past(bus_req));

    p_sts_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !sts_wr |=> ((sts_flat & $past(sts_flat)) == $past(sts_flat)));

    p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_irq != '0) |-> ((dir_flat & ena_flat & sts_flat) != '0));

    p_output_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fen_flat & ~dir_flat & ~pad_oe) == '0));

    p_input_floats_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((fen_flat & dir_flat & pad_oe) == '0));
endmodule

bind pin_irq_ctrl pin_irq_chk #(.NUM_BANKS(NUM_BANKS), .PINS(PINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_req   (bus_req),
    .bus_ready (bus_ready),
    .bank_irq  (bank_irq),
    .pad_oe    (pad_oe),
    .dir_flat  (dir_flat),
    .ena_flat  (ena_flat),
    .sts_flat  (sts_flat),
    .fen_flat  (fen_flat),
    .sts_wr    (sts_wr)
);

// File: tb/pin_irq_ctrl_test.sv
module pin_irq_ctrl_test;
    localparam int NB  = 3;
    localparam int NP  = 30;
    localparam int TOT = NB * NP;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_req = 1'b0;
    logic bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic bus_ready;
    logic [TOT-1:0] pad_in = '1;
    logic [TOT-1:0] pad_out, pad_oe, fn_gpio;
    logic [TOT-1:0] alt_out = '0;
    logic [TOT-1:0] alt_oe = '0;
    logic [NB-1:0] bank_irq;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    pin_irq_ctrl #(.NUM_BANKS(NB), .PINS(NP)) uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .alt_out(alt_out), .alt_oe(alt_oe),
        .fn_gpio(fn_gpio), .bank_irq(bank_irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic we, input logic [7:0] a, input logic [31:0] d,
                        output logic [31:0] q);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        q = bus_rdata;
        if (bus_ready !== 1'b1) begin
            tests++; fails++;
            $display("FAIL R12 ready actual=%b expected=1", bus_ready);
        end
        bus_req = 1'b0; bus_we = 1'b0;
        @(posedge clk);
        @(posedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic [31:0] q;
        xfer(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] q);
        xfer(1'b0, a, 32'h0, q);
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] q;
        rd(a, q);
        check(tag, q, exp);
    endtask

    task automatic set_pad(input int idx, input logic v);
        @(negedge clk);
        pad_in[idx] = v;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_r1;
        check("R1 irq", 32'(bank_irq), 32'h0);
        for (int b = 0; b < NB; b++) rd_check("R1 dir", 8'(8'h00 + 4*b), 32'h3FFF_FFFF);
        rd_check("R1 pol", 8'h20, 32'h0);
        rd_check("R1 typ", 8'h30, 32'h0);
        rd_check("R1 ena", 8'h44, 32'h0);
        rd_check("R1 sts", 8'h58, 32'h0);
        rd_check("R1 fen", 8'h60, 32'h0);
        rd_check("R1 dout", 8'h84, 32'h0);
    endtask

    task automatic t_handshake_r12;
        @(negedge clk);
        bus_req = 1'b1; bus_we = 1'b0; bus_addr = 8'h04;
        check("R12 ready before accept", 32'(bus_ready), 32'h0);
        @(negedge clk);
        check("R12 ready after accept", 32'(bus_ready), 32'h1);
        check("R12 rdata", bus_rdata, 32'h3FFF_FFFF);
        @(negedge clk);
        check("R12 ready while held 1", 32'(bus_ready), 32'h0);
        @(negedge clk);
        check("R12 ready while held 2", 32'(bus_ready), 32'h0);
        bus_req = 1'b0;
        @(posedge clk);
    endtask

    task automatic t_map_r2_r3;
        wr(8'h84, 32'hFFFF_FFFF);
        rd_check("R2 top bits zero", 8'h84, 32'h3FFF_FFFF);
        wr(8'h80, 32'h0000_0001);
        wr(8'h84, 32'h0000_0002);
        wr(8'h88, 32'h0000_0004);
        rd_check("R3 bank0 word", 8'h80, 32'h1);
        rd_check("R3 bank1 word", 8'h84, 32'h2);
        rd_check("R3 bank2 word", 8'h88, 32'h4);
        wr(8'h10, 32'h1234_5678);
        rd_check("R2 group1 unmapped", 8'h10, 32'h0);
        wr(8'h8C, 32'h0000_00FF);
        rd_check("R2 bank3 unmapped", 8'h8C, 32'h0);
        wr(8'h81, 32'h0000_0000);
        rd_check("R2 misaligned ignored", 8'h80, 32'h1);
        rd_check("R2 misaligned reads zero", 8'h81, 32'h0);
        wr(8'h80, 32'h0); wr(8'h84, 32'h0); wr(8'h88, 32'h0);
    endtask

    task automatic t_pads_r4_r5;
        alt_out[1] = 1'b1; alt_oe[1] = 1'b1;
        wr(8'h60, 32'h0000_0001);
        wr(8'h00, 32'h3FFF_FFFE);
        wr(8'h80, 32'h0000_0001);
        check("R4 oe output pin", 32'(pad_oe[0]), 32'h1);
        check("R4 out output pin", 32'(pad_out[0]), 32'h1);
        check("R5 alt out", 32'(pad_out[1]), 32'h1);
        check("R5 alt oe", 32'(pad_oe[1]), 32'h1);
        check("R5 fn_gpio", 32'(fn_gpio[1:0]), 32'h1);
        wr(8'h00, 32'h3FFF_FFFF);
        check("R4 oe input pin", 32'(pad_oe[0]), 32'h0);
        wr(8'h60, 32'h0);
        wr(8'h80, 32'h0);
        alt_out[1] = 1'b0; alt_oe[1] = 1'b0;
    endtask

    task automatic t_din_r6;
        @(negedge clk);
        pad_in[89:60] = 30'h1555_5555;
        settle(3);
        rd_check("R6 input word", 8'h78, 32'h1555_5555);
        @(negedge clk);
        pad_in[89:60] = '1;
        settle(3);
        wr(8'h58, 32'h0);
        rd_check("R6 input restored", 8'h78, 32'h3FFF_FFFF);
    endtask

    task automatic t_rise_r7_r13;
        set_pad(33, 1'b0);
        wr(8'h34, 32'h8);
        wr(8'h24, 32'h8);
        wr(8'h44, 32'h8);
        wr(8'h54, 32'h0);
        set_pad(33, 1'b1);
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R13 irq not before 3rd edge", 32'(bank_irq[1]), 32'h0);
        @(posedge clk);
        @(negedge clk);
        check("R13 irq at 3rd edge", 32'(bank_irq[1]), 32'h1);
        set_pad(33, 1'b0);
        settle(4);
        rd_check("R7 rising status sticky", 8'h54, 32'h8);
    endtask

    task automatic t_ack_r10;
        wr(8'h54, 32'hFFFF_FFFF);
        rd_check("R10 write one keeps", 8'h54, 32'h8);
        wr(8'h54, ~32'h8);
        rd_check("R10 write zero clears", 8'h54, 32'h0);
        check("R10 irq drops", 32'(bank_irq[1]), 32'h0);
    endtask

    task automatic t_fall_r8;
        wr(8'h30, 32'h20);
        wr(8'h40, 32'h20);
        wr(8'h50, 32'h0);
        set_pad(5, 1'b0);
        settle(3);
        check("R8 irq on falling", 32'(bank_irq[0]), 32'h1);
        rd_check("R8 falling status", 8'h50, 32'h20);
        wr(8'h50, 32'h0);
        set_pad(5, 1'b1);
        settle(4);
        rd_check("R8 rising ignored", 8'h50, 32'h0);
        check("R8 irq stays low", 32'(bank_irq[0]), 32'h0);
    endtask

    task automatic t_level_r9;
        set_pad(67, 1'b0);
        wr(8'h28, 32'h80);
        wr(8'h48, 32'h80);
        wr(8'h58, 32'h0);
        rd_check("R9 inactive level no status", 8'h58, 32'h0);
        set_pad(67, 1'b1);
        settle(3);
        rd_check("R9 active level sets", 8'h58, 32'h80);
        wr(8'h58, 32'h0);
        rd_check("R9 clear does not stick", 8'h58, 32'h80);
        set_pad(67, 1'b0);
        settle(3);
        wr(8'h58, 32'h0);
        rd_check("R9 clear sticks after level gone", 8'h58, 32'h0);
    endtask

    task automatic t_irq_gate_r11;
        set_pad(67, 1'b1);
        settle(3);
        check("R11 irq with all three", 32'(bank_irq), 32'h4);
        wr(8'h48, 32'h0);
        check("R11 masked pin", 32'(bank_irq[2]), 32'h0);
        wr(8'h48, 32'h80);
        wr(8'h08, 32'h3FFF_FF7F);
        check("R11 output pin no irq", 32'(bank_irq[2]), 32'h0);
        rd_check("R11 status still set", 8'h58, 32'h80);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        t_reset_r1();
        t_handshake_r12();
        t_map_r2_r3();
        t_pads_r4_r5();
        t_din_r6();
        t_rise_r7_r13();
        t_ack_r10();
        t_fall_r8();
        t_level_r9();
        t_irq_gate_r11();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule